// File: doc/BRIEF.md
# Key-Gated RAM Erase and Page Write Guard

This block guards a secondary working RAM and a smaller crypto RAM beside it. Software reaches it through a small register bus of single-cycle accesses. A hardware erase of both memories is started by setting an erase-start bit. That bit only takes effect after an exact two-write key sequence has been written to the key register. Once running, an internal engine writes zero to one word of each memory per clock until both are clear. A busy flag stays high for the whole erase.

The block also holds one write-protect bit per 1 KB page of the secondary RAM. Software can set these bits, and only a reset clears them. Bus writes headed for the secondary RAM pass through the block's filter. A write that hits a protected page is dropped and raises a violation pulse. Writes that are allowed are forwarded unchanged to the RAM write port. While an erase runs, the engine owns both RAM write ports.

Top module: `ram_erase_guard`

## Requirements
- R1: After reset, every register reads 0, busy is 0, no page is protected, and neither RAM write port is active.
- R2: Writing 8'hCA and then 8'h53 to the key register (register index 1, bits 7:0) unlocks erase. A following write with bit 0 set to the control register (index 0) then starts an erase. Busy (control bit 1) and the erase-start bit (control bit 0) read 1 from the next cycle on.
- R3: Any key write whose value breaks the sequence locks erase again, and the sequence restarts from 8'hCA. A start request made while locked is ignored.
- R4: A successful start consumes the unlock, so a second start needs the full key sequence again.
- R5: An erase lasts max(RAM_WORDS, CRAM_WORDS) cycles. In cycle i it writes zero to secondary address i while i < RAM_WORDS, and asserts the crypto RAM write at address i while i < CRAM_WORDS. Afterwards busy and the erase-start bit read 0.
- R6: A start request while busy is ignored. The running erase ends at its original cycle, and an unlock obtained during the erase is not consumed.
- R7: Write-protect registers start at index 2. Page p sits at index 2 + p/32, bit p%32. Writing a 1 sets a bit. Writing a 0 leaves it unchanged.
- R8: When no erase runs, a bus write to an unprotected page is forwarded that cycle with the same address and data. A bus write to a protected page is dropped and raises wr_viol for that cycle only.
- R9: During an erase, bus writes are not forwarded and raise no violation. The RAM write data is zero.
- R10: The key register and unmapped register indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_we | input | 1 | Secondary RAM write request |
| bus_addr | input | MAW | Secondary RAM word address of the request |
| bus_wdata | input | DW | Write data of the request |
| ram_we | output | 1 | Secondary RAM write enable |
| ram_addr | output | MAW | Secondary RAM word address |
| ram_wdata | output | DW | Secondary RAM write data |
| cram_we | output | 1 | Crypto RAM write enable (the data written is zero) |
| cram_addr | output | CAW | Crypto RAM word address |
| wr_viol | output | 1 | One-cycle pulse for a blocked protected-page write |

## Verification
The bench builds the block with PAGES=4, PAGE_WORDS=4 and CRAM_WORDS=20. The secondary RAM is then 16 words, and the crypto RAM is longer than it. This makes the filter sweep exhaustive: all 16 protection patterns against all 16 addresses. It also shows the secondary write enable dropping while the crypto port keeps going. The short 20-cycle erase allows every one of the 256 key values to be tried in both the first and second position of the sequence. It also lets the erase be checked word by word, including a start request placed in the middle of it.

// File: rtl/ram_guard_pkg.sv
package ram_guard_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_KEY  = 1;
  localparam int unsigned REG_WP0  = 2;

  // next unlock state after a key write
  function automatic key_state_e key_step(key_state_e s, logic [7:0] k);
    if (k == KEY_FIRST)                      return KS_HALF;
    else if (k == KEY_SECOND && s == KS_HALF) return KS_OPEN;
    else                                      return KS_LOCKED;
  endfunction

  function automatic logic below(int unsigned i, int unsigned lim);
    return i < lim;
  endfunction

  function automatic int unsigned wp_reg_of(int unsigned page);
    return REG_WP0 + page / 32;
  endfunction

  function automatic int unsigned wp_bit_of(int unsigned page);
    return page % 32;
  endfunction

endpackage

// File: rtl/key_gate.sv
module key_gate
  import ram_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       start_req,
  input  logic       busy,
  output logic       start_fire,
  output logic       unlocked
);

  key_state_e state;

  assign unlocked   = (state == KS_OPEN);
  assign start_fire = start_req & unlocked & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n)          state <= KS_LOCKED;
    else if (start_fire) state <= KS_LOCKED;
    else if (key_wr)     state <= key_step(state, key_val);
  end

  a_r4_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> !unlocked);

  a_r3_bad_key_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_val != KEY_FIRST && key_val != KEY_SECOND) |=> (state == KS_LOCKED));

  a_r2_pair_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !start_req && key_val == KEY_SECOND && state == KS_HALF) |=> unlocked);

  a_r6_busy_keeps_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && unlocked && !key_wr) |=> unlocked);

endmodule

// File: rtl/erase_engine.sv
module erase_engine
  import ram_guard_pkg::*;
#(
  parameter int unsigned RAM_WORDS  = 16384,
  parameter int unsigned CRAM_WORDS = 1024,
  localparam int unsigned ERASE_LEN = (RAM_WORDS > CRAM_WORDS) ? RAM_WORDS : CRAM_WORDS,
  localparam int unsigned EW  = $clog2(ERASE_LEN),
  localparam int unsigned MAW = $clog2(RAM_WORDS),
  localparam int unsigned CAW = $clog2(CRAM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           e_ram_we,
  output logic [MAW-1:0] e_ram_addr,
  output logic           e_cram_we,
  output logic [CAW-1:0] e_cram_addr
);

  localparam logic [EW-1:0] LAST = EW'(ERASE_LEN - 1);

  logic [EW-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign e_ram_we    = busy & below(32'(idx), RAM_WORDS);
  assign e_cram_we   = busy & below(32'(idx), CRAM_WORDS);
  assign e_ram_addr  = idx[MAW-1:0];
  assign e_cram_addr = idx[CAW-1:0];

  a_r5_walk_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx == $past(idx) + 1'b1));

  a_r5_ends_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(idx) == LAST));

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

// File: rtl/page_guard.sv
module page_guard
  import ram_guard_pkg::*;
#(
  parameter int unsigned PAGES      = 64,
  parameter int unsigned PAGE_WORDS = 256,
  parameter int unsigned REG_AW     = 3,
  parameter int unsigned DW         = 32,
  localparam int unsigned MAW = $clog2(PAGES * PAGE_WORDS),
  localparam int unsigned PB  = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              bus_we,
  input  logic [MAW-1:0]    bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              erase_busy,
  output logic [31:0]       wp_rdata,
  output logic              fwd_we,
  output logic [MAW-1:0]    fwd_addr,
  output logic [DW-1:0]     fwd_wdata,
  output logic              wr_viol
);

  logic [PAGES-1:0] wp;

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    localparam int unsigned RIDX = wp_reg_of(p);
    localparam int unsigned BIDX = wp_bit_of(p);
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else if (reg_we && reg_addr == REG_AW'(RIDX) && reg_wdata[BIDX])
        bit_q <= 1'b1;
    end
    assign wp[p] = bit_q;
  end

  always_comb begin
    wp_rdata = '0;
    for (int p = 0; p < PAGES; p++)
      if (reg_addr == REG_AW'(wp_reg_of(p))) wp_rdata[wp_bit_of(p)] = wp[p];
  end

  logic hit_prot;
  assign hit_prot  = wp[bus_addr[MAW-1:PB]];
  assign fwd_we    = bus_we & ~erase_busy & ~hit_prot;
  assign wr_viol   = bus_we & ~erase_busy & hit_prot;
  assign fwd_addr  = bus_addr;
  assign fwd_wdata = bus_wdata;

  a_r7_wp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((wp & $past(wp)) == $past(wp)));

  a_r8_blocked_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |-> !fwd_we);

endmodule

// File: rtl/ram_erase_guard.sv
module ram_erase_guard
  import ram_guard_pkg::*;
#(
  parameter int unsigned PAGES      = 64,
  parameter int unsigned PAGE_WORDS = 256,
  parameter int unsigned CRAM_WORDS = 1024,
  parameter int unsigned DW         = 32,
  parameter int unsigned REG_AW     = 3,
  localparam int unsigned RAM_WORDS = PAGES * PAGE_WORDS,
  localparam int unsigned MAW       = $clog2(RAM_WORDS),
  localparam int unsigned CAW       = $clog2(CRAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic              bus_we,
  input  logic [MAW-1:0]    bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              ram_we,
  output logic [MAW-1:0]    ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              cram_we,
  output logic [CAW-1:0]    cram_addr,
  output logic              wr_viol
);

  logic ctrl_wr, key_wr, start_fire, unlocked, busy;
  logic e_ram_we;
  logic [MAW-1:0] e_ram_addr;
  logic fwd_we;
  logic [MAW-1:0] fwd_addr;
  logic [DW-1:0]  fwd_wdata;
  logic [31:0]    wp_rdata;

  assign ctrl_wr = reg_we && reg_addr == REG_AW'(REG_CTRL);
  assign key_wr  = reg_we && reg_addr == REG_AW'(REG_KEY);

  key_gate u_key (
    .clk(clk), .rst_n(rst_n),
    .key_wr(key_wr), .key_val(reg_wdata[7:0]),
    .start_req(ctrl_wr & reg_wdata[0]), .busy(busy),
    .start_fire(start_fire), .unlocked(unlocked)
  );

  erase_engine #(.RAM_WORDS(RAM_WORDS), .CRAM_WORDS(CRAM_WORDS)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(start_fire), .busy(busy),
    .e_ram_we(e_ram_we), .e_ram_addr(e_ram_addr),
    .e_cram_we(cram_we), .e_cram_addr(cram_addr)
  );

  page_guard #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .REG_AW(REG_AW), .DW(DW)) u_guard (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .erase_busy(busy), .wp_rdata(wp_rdata),
    .fwd_we(fwd_we), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata),
    .wr_viol(wr_viol)
  );

  // erase engine owns the secondary RAM port while busy
  assign ram_we    = busy ? e_ram_we   : fwd_we;
  assign ram_addr  = busy ? e_ram_addr : fwd_addr;
  assign ram_wdata = busy ? '0         : fwd_wdata;

  always_comb begin
    reg_rdata = wp_rdata;
    if (reg_addr == REG_AW'(REG_CTRL)) reg_rdata = {30'd0, busy, busy};
  end

  a_r2_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ctrl_wr) && $past(reg_wdata[0]) && $past(unlocked)));

  a_r9_erase_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_viol && ram_wdata == '0));

  a_r8_viol_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_viol |-> !ram_we);

endmodule

// File: tb/ram_erase_guard_bench.sv
`timescale 1ns/1ps
module ram_erase_guard_bench;

  localparam int PAGES = 4, PAGE_WORDS = 4, CRAM_WORDS = 20;
  localparam int RAM_WORDS = PAGES * PAGE_WORDS;
  localparam int ELEN = (RAM_WORDS > CRAM_WORDS) ? RAM_WORDS : CRAM_WORDS;
  localparam int MAW = $clog2(RAM_WORDS), CAW = $clog2(CRAM_WORDS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, bus_we = 1'b0;
  logic [MAW-1:0] bus_addr = '0, ram_addr;
  logic [31:0] bus_wdata = '0, ram_wdata;
  logic ram_we, cram_we, wr_viol;
  logic [CAW-1:0] cram_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ram_erase_guard #(.PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .CRAM_WORDS(CRAM_WORDS),
                    .DW(32), .REG_AW(3)) u_ram_erase_guard (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cram_we(cram_we), .cram_addr(cram_addr), .wr_viol(wr_viol)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0; reg_we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic rw(int a, logic [31:0] d);
    @(negedge clk); reg_addr = 3'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); reg_addr = 3'(a); #1 v = reg_rdata;
  endtask

  task automatic drain();
    logic [31:0] v;
    for (int g = 0; g < 100; g++) begin
      rd(0, v);
      if (v[1] == 1'b0) break;
    end
  endtask

  // start request; reports whether busy was seen afterwards
  task automatic try_start(output bit started);
    logic [31:0] v;
    rw(0, 32'h1);
    rd(0, v);
    started = v[1];
    if (started) drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit st;
    do_reset();

    // R1 / R10 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R10 key reads 0", v, 0);
    rd(2, v); chk("R1 wp", v, 0);
    rd(3, v); chk("R10 unmapped", v, 0);
    chk("R1 ram_we", 32'(ram_we), 0);
    chk("R1 cram_we", 32'(cram_we), 0);
    chk("R1 viol", 32'(wr_viol), 0);
    try_start(st); chk("R3 start while locked", 32'(st), 0);

    // R7 / R8 exhaustive filter sweep
    for (int pat = 0; pat < 16; pat++) begin
      do_reset();
      rw(2, 32'(pat & 5));
      rw(2, 32'(pat & 10));
      rw(2, 32'h0);
      rd(2, v); chk("R7 set-only wp", v, 32'(pat));
      for (int a = 0; a < RAM_WORDS; a++) begin
        bit prot;
        prot = pat[a / PAGE_WORDS];
        @(negedge clk);
        bus_we = 1'b1; bus_addr = MAW'(a); bus_wdata = 32'h5A000000 | 32'(pat << 8) | 32'(a);
        #1;
        chk("R8 forward", 32'(ram_we), 32'(!prot));
        chk("R8 viol", 32'(wr_viol), 32'(prot));
        if (!prot) begin
          chk("R8 addr", 32'(ram_addr), 32'(a));
          chk("R8 data", ram_wdata, bus_wdata);
        end
      end
      @(negedge clk); bus_we = 1'b0; #1;
      chk("R8 viol single cycle", 32'(wr_viol), 0);
    end

    // R2 / R3 key value sweeps
    do_reset();
    for (int k = 0; k < 256; k++) begin
      rw(1, 32'hCA); rw(1, 32'(k));
      try_start(st);
      chk("R2 R3 second key", 32'(st), 32'(k == 8'h53));
    end
    for (int k = 0; k < 256; k++) begin
      rw(1, 32'(k)); rw(1, 32'h53);
      try_start(st);
      chk("R2 R3 first key", 32'(st), 32'(k == 8'hCA));
    end
    rw(1, 32'hCA); rw(1, 32'h53); rw(1, 32'h00);
    try_start(st); chk("R3 wrong key after unlock", 32'(st), 0);

    // R4 unlock consumed
    rw(1, 32'hCA); rw(1, 32'h53);
    try_start(st); chk("R4 first start", 32'(st), 1);
    try_start(st); chk("R4 second start needs key", 32'(st), 0);

    // R5 / R9 erase walk with a competing protected bus write
    do_reset();
    rw(2, 32'h1);
    rw(1, 32'hCA); rw(1, 32'h53);
    rw(0, 32'h1);
    bus_we = 1'b1; bus_addr = MAW'(3); bus_wdata = 32'hFFFF0000;
    for (int i = 0; i < ELEN; i++) begin
      #1;
      chk("R5 ram_we", 32'(ram_we), 32'(i < RAM_WORDS));
      if (i < RAM_WORDS) chk("R5 ram_addr", 32'(ram_addr), 32'(i));
      chk("R5 cram_we", 32'(cram_we), 32'(i < CRAM_WORDS));
      chk("R5 cram_addr", 32'(cram_addr), 32'(i));
      chk("R9 zero data", ram_wdata, 0);
      chk("R9 no viol", 32'(wr_viol), 0);
      chk("R5 busy", reg_rdata, 3);
      @(negedge clk);
    end
    #1;
    chk("R5 ctrl clear", reg_rdata, 0);
    chk("R9 viol after erase", 32'(wr_viol), 1);
    chk("R5 ram port idle", 32'(ram_we), 0);
    chk("R5 cram idle", 32'(cram_we), 0);
    @(negedge clk); bus_we = 1'b0;

    // R6 start during busy ignored, unlock kept
    do_reset();
    rw(1, 32'hCA); rw(1, 32'h53);
    rw(0, 32'h1);
    rw(1, 32'hCA); rw(1, 32'h53); rw(0, 32'h1);
    begin
      int n;
      n = 0;
      for (int g = 0; g < 100; g++) begin
        #1;
        if (reg_rdata[1] == 1'b0) break;
        n++;
        @(negedge clk);
      end
      chk("R6 erase length unchanged", 32'(n), 32'(ELEN - 6));
    end
    try_start(st); chk("R6 unlock kept", 32'(st), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule